// File: doc/BRIEF.md
# DDR Write Lane Launcher

This block forms the write-side waveforms of one byte lane of a double-data-rate memory interface. It produces data, mask and strobe. The controller issues a one-slot write command together with a burst-length code. With that command, and on each following controller clock of the burst, it supplies two beats of data and mask. After one controller clock of latency the block drives the strobe low for a half-cycle preamble. It then toggles the strobe once per beat and drives each data and mask beat so that the strobe edge falls in the middle of that beat. A half-cycle low postamble follows the last beat, and then the strobe is released.

The block runs on a single internal clock, `clk2x`, at twice the controller rate. One `clk2x` period (a "slot") is one half controller clock, which is one beat. Strobe and enables change only on rising `clk2x` edges. Data, mask and the data enable change only on falling `clk2x` edges. The quarter-cycle offset between the two groups models the 90 degree centring of the strobe. The slot after reset release is a controller rising-edge slot, and the slot types then alternate. If a new command arrives in the first free controller slot after a burst, the strobe and data continue with no gap.

Top module: `ddrw_lane_launcher`

## Requirements
- R1: While reset is applied, and after any clock edge at which reset is sampled, `dqs_oe`, `dqs`, `dq_oe`, `dq` and `dm` are all zero. This holds even in the middle of a burst.
- R2: The first rising `clk2x` edge after reset release is a controller rising-edge slot, and the slot types alternate from there. A `wr_cmd` sampled in any other slot is ignored.
- R3: `bl_sel` selects the burst length: code 0 gives 2 beats, 1 gives 4 beats and 2 gives 8 beats. The reserved code 3 gives 4 beats.
- R4: For a command accepted at rising edge C, `dqs_oe` rises at edge C+1 with `dqs` low (preamble). The first `dqs` rising transition is at edge C+2, one controller clock after the command.
- R5: For beat k of a burst, `dqs` is set at rising edge C+2+k: high for even k and low for odd k. The strobe therefore toggles once per beat.
- R6: Beat k is driven on `dq`/`dq_oe` from the falling edge before C+2+k until the falling edge after it, so each strobe edge sits mid-beat. `dq` never changes on a rising edge and `dqs` never changes on a falling edge.
- R7: Beat order: `wr_data[7:0]` is the earlier beat and `wr_data[15:8]` the later beat of a pair. Pairs are taken at edge C and at each following controller rising-edge slot until all L beats are taken.
- R8: `dm` carries `wr_mask[0]` with the earlier beat and `wr_mask[1]` with the later beat, with exactly the data timing.
- R9: After the last beat's low strobe level, `dqs` stays low and enabled for that half-cycle postamble. `dqs_oe` falls at edge C+2+L.
- R10: A command that arrives in a controller slot while pairs of the current burst are still to be taken is ignored. Its data is not used and its beats never appear.
- R11: A command accepted in the first free controller slot (edge C+L) continues seamlessly: `dqs_oe` and `dq_oe` stay high and the strobe keeps toggling with no extra low half-cycle.
- R12: Outside a burst, `dq_oe` is low and `dq` and `dm` are zero. `dq_oe` is high for exactly L half-cycles per burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2x | input | 1 | Internal clock at twice the controller rate; one period is one beat |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_cmd | input | 1 | Write command, sampled in controller rising-edge slots |
| bl_sel | input | 2 | Burst-length code, sampled with the command |
| wr_data | input | 16 | Two data beats; low byte is the earlier beat |
| wr_mask | input | 2 | Two mask beats; bit 0 is the earlier beat |
| dq | output | 8 | Lane data, launched on falling `clk2x` edges |
| dm | output | 1 | Lane write mask, timed like `dq` |
| dq_oe | output | 1 | Drive enable for `dq` and `dm` |
| dqs | output | 1 | Strobe level, launched on rising `clk2x` edges |
| dqs_oe | output | 1 | Drive enable for the strobe; low means tri-stated |

## Verification
A wrong beat counter or parity bit appears at the ports within one slot. It shows as a strobe that fails to toggle between adjacent beats, a data byte taken from the wrong half of a pair, or a `dq_oe` window one half-cycle too long or too short. A wrong pair-fetch count shows up at the next controller slot. That slot either accepts a command it should ignore, which adds a preamble or a mis-ordered beat, or refuses a back-to-back command, which drops `dqs_oe` for a slot. A phase bit that is off by one slot moves every strobe transition half a controller clock, and the first checked edge after a command exposes it.

// File: rtl/ddrw_pkg.sv
// Package: shared constants and the burst-length decode for the write lane.
// Assumes at most eight beats per burst.
package ddrw_pkg;

    localparam int MAX_BEATS = 8;
    localparam int BEAT_CW   = $clog2(MAX_BEATS + 1);

    typedef enum logic [1:0] {
        BL_TWO   = 2'd0,
        BL_FOUR  = 2'd1,
        BL_EIGHT = 2'd2,
        BL_RSVD  = 2'd3
    } bl_code_e;

    // Beats per burst for a length code; the reserved code gives four (R3).
    function automatic logic [BEAT_CW-1:0] beats_of(input logic [1:0] code);
        case (bl_code_e'(code))
            BL_TWO:   beats_of = BEAT_CW'(2);
            BL_EIGHT: beats_of = BEAT_CW'(8);
            default:  beats_of = BEAT_CW'(4);
        endcase
    endfunction

endpackage

// File: rtl/ddrw_phase_gen.sv
// Module: marks which clk2x slots line up with the controller clock's rising edge.
// Assumes the controller clock is phase-locked so that its rising edge falls on the
// first clk2x slot after reset release.
module ddrw_phase_gen (
    input  logic clk2x,
    input  logic rst_n,
    output logic ck_rise_slot
);

    logic half_q;

    // Toggle once per slot; cleared by reset so slot 0 is a rising-edge slot.
    always_ff @(posedge clk2x) begin
        if (!rst_n) half_q <= 1'b0;
        else        half_q <= ~half_q;
    end

    assign ck_rise_slot = ~half_q;

endmodule

// File: rtl/ddrw_burst_seq.sv
// Module: accepts write commands, fetches beat pairs once per controller clock and
// stages one beat per slot. Assumes the controller presents a pair with the command
// and on each following controller slot of the burst.
module ddrw_burst_seq
    import ddrw_pkg::*;
#(
    parameter int DQ_W = 8,
    parameter int DM_W = 1
) (
    input  logic              clk2x,
    input  logic              rst_n,
    input  logic              ck_rise_slot,
    input  logic              wr_cmd,
    input  logic [1:0]        bl_sel,
    input  logic [2*DQ_W-1:0] wr_data,
    input  logic [2*DM_W-1:0] wr_mask,
    output logic              stage_now,
    output logic              st_vld,
    output logic              st_even,
    output logic [DQ_W-1:0]   st_dq,
    output logic [DM_W-1:0]   st_dm
);

    logic [BEAT_CW-1:0] pairs_left;
    logic [BEAT_CW-1:0] beats_left;
    logic               odd_q;
    logic [2*DQ_W-1:0]  pair_dq;
    logic [2*DM_W-1:0]  pair_dm;
    logic               accept;
    logic               fetch;
    logic [BEAT_CW-1:0] new_len;

    assign new_len   = beats_of(bl_sel);
    assign accept    = ck_rise_slot && wr_cmd && (pairs_left == '0);
    assign fetch     = ck_rise_slot && (pairs_left != '0);
    assign stage_now = (beats_left != '0);

    // Capture a data/mask pair on command acceptance or on a pending fetch.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            pair_dq <= '0;
            pair_dm <= '0;
        end else if (accept || fetch) begin
            pair_dq <= wr_data;
            pair_dm <= wr_mask;
        end
    end

    // Count the pairs still owed by the controller for the current burst.
    always_ff @(posedge clk2x) begin
        if (!rst_n)      pairs_left <= '0;
        else if (accept) pairs_left <= (new_len >> 1) - BEAT_CW'(1);
        else if (fetch)  pairs_left <= pairs_left - BEAT_CW'(1);
    end

    // Count beats left to stage and track which half of the pair comes next.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            beats_left <= '0;
            odd_q      <= 1'b0;
        end else if (accept) begin
            beats_left <= new_len;
            odd_q      <= 1'b0;
        end else if (stage_now) begin
            beats_left <= beats_left - BEAT_CW'(1);
            odd_q      <= ~odd_q;
        end
    end

    // Stage this slot's beat from the earlier or later half of the held pair.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            st_vld  <= 1'b0;
            st_even <= 1'b0;
            st_dq   <= '0;
            st_dm   <= '0;
        end else begin
            st_vld  <= stage_now;
            st_even <= ~odd_q;
            st_dq   <= !stage_now ? '0 :
                       (odd_q ? pair_dq[2*DQ_W-1:DQ_W] : pair_dq[DQ_W-1:0]);
            st_dm   <= !stage_now ? '0 :
                       (odd_q ? pair_dm[2*DM_W-1:DM_W] : pair_dm[DM_W-1:0]);
        end
    end

    // R10: a new burst is only taken once the previous one is on its final beat.
    a_r10_no_overlap: assert property (@(posedge clk2x) disable iff (!rst_n)
        accept |-> (beats_left <= BEAT_CW'(1)));

endmodule

// File: rtl/ddrw_strobe_gen.sv
// Module: builds the strobe level and enable on rising clk2x edges, one slot behind
// the beat staging, giving preamble, per-beat toggling and postamble. Assumes every
// burst has an even number of beats.
module ddrw_strobe_gen (
    input  logic clk2x,
    input  logic rst_n,
    input  logic stage_now,
    input  logic st_vld,
    input  logic st_even,
    output logic dqs,
    output logic dqs_oe
);

    // Enable spans the preamble slot through the postamble slot; level follows beat parity.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            dqs    <= 1'b0;
            dqs_oe <= 1'b0;
        end else begin
            dqs    <= st_vld && st_even;
            dqs_oe <= stage_now || st_vld;
        end
    end

    // R4: the strobe is enabled low first (preamble).
    a_r4_preamble_low: assert property (@(posedge clk2x) disable iff (!rst_n)
        $rose(dqs_oe) |-> !dqs);

    // R9: the last enabled level before release is low (postamble).
    a_r9_postamble_low: assert property (@(posedge clk2x) disable iff (!rst_n)
        $fell(dqs_oe) |-> !$past(dqs));

endmodule

// File: rtl/ddrw_edge_shift.sv
// Module: launches the staged beat on the falling clk2x edge, half a slot before the
// strobe edge that belongs to it. Assumes staged values are zero outside a burst.
module ddrw_edge_shift #(
    parameter int DQ_W = 8,
    parameter int DM_W = 1
) (
    input  logic            clk2x,
    input  logic            rst_n,
    input  logic            st_vld,
    input  logic [DQ_W-1:0] st_dq,
    input  logic [DM_W-1:0] st_dm,
    output logic [DQ_W-1:0] dq,
    output logic [DM_W-1:0] dm,
    output logic            dq_oe
);

    // Falling-edge launch of data, mask and data enable.
    always_ff @(negedge clk2x) begin
        if (!rst_n) begin
            dq    <= '0;
            dm    <= '0;
            dq_oe <= 1'b0;
        end else begin
            dq    <= st_dq;
            dm    <= st_dm;
            dq_oe <= st_vld;
        end
    end

endmodule

// File: rtl/ddrw_lane_launcher.sv
// Module: top of the write-side launcher for one byte lane. Joins the phase marker,
// burst sequencer, strobe generator and falling-edge data launch.
// Assumes clk2x runs at twice the controller clock and reset is synchronous.
module ddrw_lane_launcher #(
    parameter  int DQ_W = 8,
    localparam int DM_W = DQ_W / 8
) (
    input  logic              clk2x,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic [1:0]        bl_sel,
    input  logic [2*DQ_W-1:0] wr_data,
    input  logic [2*DM_W-1:0] wr_mask,
    output logic [DQ_W-1:0]   dq,
    output logic [DM_W-1:0]   dm,
    output logic              dq_oe,
    output logic              dqs,
    output logic              dqs_oe
);

    logic            ck_rise_slot;
    logic            stage_now;
    logic            st_vld;
    logic            st_even;
    logic [DQ_W-1:0] st_dq;
    logic [DM_W-1:0] st_dm;

    ddrw_phase_gen u_phase (
        .clk2x        (clk2x),
        .rst_n        (rst_n),
        .ck_rise_slot (ck_rise_slot)
    );

    ddrw_burst_seq #(.DQ_W(DQ_W), .DM_W(DM_W)) u_seq (
        .clk2x        (clk2x),
        .rst_n        (rst_n),
        .ck_rise_slot (ck_rise_slot),
        .wr_cmd       (wr_cmd),
        .bl_sel       (bl_sel),
        .wr_data      (wr_data),
        .wr_mask      (wr_mask),
        .stage_now    (stage_now),
        .st_vld       (st_vld),
        .st_even      (st_even),
        .st_dq        (st_dq),
        .st_dm        (st_dm)
    );

    ddrw_strobe_gen u_strobe (
        .clk2x     (clk2x),
        .rst_n     (rst_n),
        .stage_now (stage_now),
        .st_vld    (st_vld),
        .st_even   (st_even),
        .dqs       (dqs),
        .dqs_oe    (dqs_oe)
    );

    ddrw_edge_shift #(.DQ_W(DQ_W), .DM_W(DM_W)) u_shift (
        .clk2x  (clk2x),
        .rst_n  (rst_n),
        .st_vld (st_vld),
        .st_dq  (st_dq),
        .st_dm  (st_dm),
        .dq     (dq),
        .dm     (dm),
        .dq_oe  (dq_oe)
    );

    // R6: a driven data beat always sits inside the strobe's enabled window.
    a_r6_data_in_strobe: assert property (@(posedge clk2x) disable iff (!rst_n)
        dq_oe |-> dqs_oe);

    // R5: across consecutive driven beats the strobe changes level every slot.
    a_r5_strobe_toggles: assert property (@(posedge clk2x) disable iff (!rst_n)
        (dq_oe && $past(dq_oe)) |-> (dqs != $past(dqs)));

endmodule

// File: tb/tb_ddrw_lane_launcher.sv
// Bench: walks a table of command scenarios through a per-slot expectation model,
// then applies a reset in the middle of a burst.
module tb_ddrw_lane_launcher;

    localparam int SEG = 40;

    typedef struct packed {
        logic [5:0] off_a;
        logic [1:0] sel_a;
        logic [7:0] seed_a;
        logic       has_b;
        logic [5:0] off_b;
        logic [1:0] sel_b;
        logic [7:0] seed_b;
        logic [4:0] req;
    } vec_t;

    // Scenarios: R3 lengths, R7/R8 order, R11 chaining, R10 busy, R2 off-phase command.
    localparam vec_t VECS [0:8] = '{
        '{6'd0, 2'd0, 8'h3C, 1'b0, 6'd0, 2'd0, 8'h00, 5'd3},
        '{6'd0, 2'd1, 8'h5A, 1'b0, 6'd0, 2'd0, 8'h00, 5'd7},
        '{6'd0, 2'd2, 8'hC3, 1'b0, 6'd0, 2'd0, 8'h00, 5'd8},
        '{6'd2, 2'd3, 8'h11, 1'b0, 6'd0, 2'd0, 8'h00, 5'd3},
        '{6'd0, 2'd1, 8'h27, 1'b1, 6'd4, 2'd2, 8'h9E, 5'd11},
        '{6'd0, 2'd2, 8'h48, 1'b1, 6'd4, 2'd1, 8'hF0, 5'd10},
        '{6'd0, 2'd1, 8'h6D, 1'b1, 6'd3, 2'd1, 8'h82, 5'd2},
        '{6'd0, 2'd0, 8'hB1, 1'b1, 6'd2, 2'd0, 8'h4E, 5'd11},
        '{6'd0, 2'd2, 8'h19, 1'b1, 6'd8, 2'd2, 8'hD7, 5'd11}
    };

    logic        clk2x = 1'b0;
    logic        rst_n;
    logic        wr_cmd;
    logic [1:0]  bl_sel;
    logic [15:0] wr_data;
    logic [1:0]  wr_mask;
    logic [7:0]  dq;
    logic [0:0]  dm;
    logic        dq_oe;
    logic        dqs;
    logic        dqs_oe;

    int n_chk = 0;
    int n_bad = 0;

    logic        exp_soe [SEG];
    logic        exp_s   [SEG];
    logic        exp_doe [SEG];
    logic [7:0]  exp_dq  [SEG];
    logic        exp_dm  [SEG];
    logic        in_cmd  [SEG];
    logic [1:0]  in_sel  [SEG];
    logic [15:0] in_d    [SEG];
    logic [1:0]  in_m    [SEG];

    always #5 clk2x = ~clk2x;

    ddrw_lane_launcher dut (
        .clk2x   (clk2x),
        .rst_n   (rst_n),
        .wr_cmd  (wr_cmd),
        .bl_sel  (bl_sel),
        .wr_data (wr_data),
        .wr_mask (wr_mask),
        .dq      (dq),
        .dm      (dm),
        .dq_oe   (dq_oe),
        .dqs     (dqs),
        .dqs_oe  (dqs_oe)
    );

    task automatic chk(input string tag, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h exp %h", tag, what, got, exp);
        end
    endtask

    function automatic int len_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return 2;
            2'd2:    return 8;
            default: return 4;
        endcase
    endfunction

    function automatic logic [7:0] beat_d(input logic [7:0] seed, input int k);
        return (seed ^ (8'(k) * 8'h29)) + 8'(k);
    endfunction

    function automatic logic beat_m(input logic [7:0] seed, input int k);
        return seed[k % 8];
    endfunction

    function automatic string tag_of(input logic [4:0] r);
        case (r)
            5'd2:    return "R2";
            5'd3:    return "R3";
            5'd7:    return "R7";
            5'd8:    return "R8";
            5'd10:   return "R10";
            5'd11:   return "R11";
            default: return "R5";
        endcase
    endfunction

    task automatic run_vec(input vec_t v);
        int busy_until = -1;
        int acc_at = -1;
        logic [7:0] acc_seed = 8'h00;
        int exp_cnt = 0;
        int obs_cnt = 0;
        string stag;
        for (int s = 0; s < SEG; s++) begin
            exp_soe[s] = 1'b0; exp_s[s] = 1'b0; exp_doe[s] = 1'b0;
            exp_dq[s] = 8'h00; exp_dm[s] = 1'b0;
        end
        // Build stimulus and expectations slot by slot from the requirements.
        for (int s = 0; s < SEG; s++) begin
            logic c;
            logic [1:0] sel;
            logic [7:0] seed;
            c    = (s == int'(v.off_a)) || (v.has_b && s == int'(v.off_b));
            sel  = (s == int'(v.off_a)) ? v.sel_a : v.sel_b;
            seed = (s == int'(v.off_a)) ? v.seed_a : v.seed_b;
            in_cmd[s] = c;
            in_sel[s] = c ? sel : 2'd0;
            if (c && (s % 2 == 0) && s > busy_until) begin
                int L;
                L = len_of(sel);
                acc_at = s; acc_seed = seed; busy_until = s + L - 2;
                for (int i = 1; i <= L + 1; i++)
                    if (s + i < SEG) exp_soe[s + i] = 1'b1;
                for (int k = 0; k < L; k++) begin
                    if (s + 2 + k < SEG) exp_s[s + 2 + k] = (k % 2 == 0);
                    if (s + 1 + k < SEG) begin
                        exp_doe[s + 1 + k] = 1'b1;
                        exp_dq[s + 1 + k]  = beat_d(seed, k);
                        exp_dm[s + 1 + k]  = beat_m(seed, k);
                    end
                end
                in_d[s] = {beat_d(seed, 1), beat_d(seed, 0)};
                in_m[s] = {beat_m(seed, 1), beat_m(seed, 0)};
            end else if (s <= busy_until && ((s - acc_at) % 2 == 0)) begin
                int j;
                j = (s - acc_at) / 2;
                in_d[s] = {beat_d(acc_seed, 2*j + 1), beat_d(acc_seed, 2*j)};
                in_m[s] = {beat_m(acc_seed, 2*j + 1), beat_m(acc_seed, 2*j)};
            end else if (c) begin
                in_d[s] = {beat_d(seed, 1), beat_d(seed, 0)};
                in_m[s] = {beat_m(seed, 1), beat_m(seed, 0)};
            end else begin
                in_d[s] = 16'hA5A5;
                in_m[s] = 2'b11;
            end
        end
        for (int s = 0; s < SEG; s++) exp_cnt += int'(exp_soe[s]);
        // Drive each slot, then sample after the rising and after the falling edge.
        for (int s = 0; s < SEG; s++) begin
            wr_cmd  = in_cmd[s];
            bl_sel  = in_sel[s];
            wr_data = in_d[s];
            wr_mask = in_m[s];
            @(posedge clk2x); #2;
            if (!exp_soe[s])                          stag = "R9";
            else if (s == 0 || !exp_soe[s - 1])       stag = "R4";
            else                                      stag = "R5";
            chk(stag, "dqs_oe", 16'(dqs_oe), 16'(exp_soe[s]));
            chk(stag, "dqs", 16'(dqs), 16'(exp_s[s]));
            if (s > 0) chk("R6", "dq_oe held over rising edge", 16'(dq_oe), 16'(exp_doe[s - 1]));
            obs_cnt += int'(dqs_oe);
            @(negedge clk2x); #2;
            chk("R12", "dq_oe", 16'(dq_oe), 16'(exp_doe[s]));
            chk("R7", "dq beat", 16'(dq), 16'(exp_dq[s]));
            chk("R8", "dm beat", 16'(dm), 16'(exp_dm[s]));
            chk("R6", "dqs held over falling edge", 16'(dqs), 16'(exp_s[s]));
        end
        chk(tag_of(v.req), "strobe-enabled slot count", 16'(obs_cnt), 16'(exp_cnt));
    endtask

    task automatic report;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        rst_n = 1'b0; wr_cmd = 1'b0; bl_sel = 2'd0; wr_data = 16'h0; wr_mask = 2'b0;
        repeat (3) @(posedge clk2x);
        @(negedge clk2x); #2;
        // R1: reset state.
        chk("R1", "reset dqs_oe", 16'(dqs_oe), 16'h0);
        chk("R1", "reset dqs", 16'(dqs), 16'h0);
        chk("R1", "reset dq_oe", 16'(dq_oe), 16'h0);
        chk("R1", "reset dq", 16'(dq), 16'h0);
        chk("R1", "reset dm", 16'(dm), 16'h0);
        rst_n = 1'b1;
        for (int v = 0; v < 9; v++) run_vec(VECS[v]);
        // R1: reset applied in the middle of an eight-beat burst.
        wr_cmd = 1'b1; bl_sel = 2'd2; wr_data = 16'h7E81; wr_mask = 2'b01;
        @(posedge clk2x);
        @(negedge clk2x); #2;
        wr_cmd = 1'b0;
        repeat (3) @(posedge clk2x);
        @(negedge clk2x); #2;
        rst_n = 1'b0;
        @(posedge clk2x); #2;
        chk("R1", "mid-burst reset dqs_oe", 16'(dqs_oe), 16'h0);
        chk("R1", "mid-burst reset dqs", 16'(dqs), 16'h0);
        @(negedge clk2x); #2;
        chk("R1", "mid-burst reset dq_oe", 16'(dq_oe), 16'h0);
        chk("R1", "mid-burst reset dq", 16'(dq), 16'h0);
        chk("R1", "mid-burst reset dm", 16'(dm), 16'h0);
        @(posedge clk2x);
        @(negedge clk2x); #2;
        rst_n = 1'b1;
        run_vec(VECS[1]);
        report();
    end

endmodule